// File: doc/BRIEF.md
# Dual-Lookup Instruction Cache with Shared Line Refill

This block is an instruction cache that answers two fetch lookups in every cycle. The two lookups come from two independent request ports, for example the older and the younger slot of a two-wide fetch unit. The ports read a common direct-mapped store. Each port compares its own tag, and on a hit it returns the addressed word in the same cycle.

There is only one path to backing memory. A single refill controller watches both ports for misses. It picks one pending miss, fetches the whole line as a burst of word beats, writes the line into the store and then picks again. A requester that misses keeps its valid and address steady until it sees ready. The other port keeps working from the store during that time.

The default geometry is 64 lines of four 32-bit words, addressed by byte. Byte address bits [3:2] select the word, bits [9:4] select the line, and bits [31:10] form the tag.

Top module: `dual_icache`

## Requirements
- R1: After reset every line is invalid, so the first lookup of any address is a miss and returns no ready.
- R2: On a hit, a port raises ready in the same cycle its valid is high and returns the word selected by byte address bits [3:2] of its line.
- R3: On a miss, the port's ready stays low until the line is filled. The refill controller then issues one memory request whose address is the missing line's base, with the low four address bits zero.
- R4: A refill accepts exactly one request handshake and then takes four response beats, stored as words 0, 1, 2, 3 in arrival order. No further request is raised until that line has been written, and afterwards every word of the line hits.
- R5: When both ports miss on different lines in the same cycle, the port 0 line is requested first.
- R6: When both ports miss on the same line, a single refill satisfies both ports.
- R7: A miss pending on one port does not hold back a hit on the other port; that hit is returned in the same cycle.
- R8: A memory request keeps its valid high and its address unchanged until it is accepted.
- R9: Placement is direct-mapped. Filling a line with a new tag evicts the old tag at that index, so the evicted address misses again.
- R10: A port's ready is never high while that port's valid is low.
- R11: While a line is being refilled, no lookup of that line's index reports a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f0_valid | input | 1 | Port 0 lookup request |
| f0_addr | input | 32 | Port 0 byte address |
| f0_ready | output | 1 | Port 0 hit, word valid this cycle |
| f0_instr | output | 32 | Port 0 returned word |
| f1_valid | input | 1 | Port 1 lookup request |
| f1_addr | input | 32 | Port 1 byte address |
| f1_ready | output | 1 | Port 1 hit, word valid this cycle |
| f1_instr | output | 32 | Port 1 returned word |
| mem_req_valid | output | 1 | Line read request to backing memory |
| mem_req_addr | output | 32 | Line base byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | One response beat is present |
| mem_rsp_data | input | 32 | Response beat data |

## Verification
The bench makes both ports miss together on distinct lines. A design that arbitrated the wrong way would send the port 1 line to memory first. It also makes both ports miss on one line, where a design without merging would issue a second, redundant request. It holds a miss on one port while the other port hits, and that hit must come back at once rather than wait behind the refill. It aliases two tags onto one index, after which a design that failed to evict would keep returning stale words. Randomly paced memory acceptance and beat gaps expose a request that drifts before acceptance or beats stored out of order.

// File: rtl/dual_icache_pkg.sv
package dual_icache_pkg;
   localparam int NUM_PORTS = 2;

   typedef enum logic [1:0] {
      RF_IDLE,
      RF_REQ,
      RF_WAIT,
      RF_UPD
   } refill_state_e;
endpackage

// File: rtl/icache_store.sv
module icache_store #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 64,
   parameter int WORDS  = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [1:0][ADDR_W-1:0]             rd_addr,
   output logic [1:0]                         rd_hit,
   output logic [1:0][DATA_W-1:0]             rd_data,
   input  logic                               fill_inval,
   input  logic                               fill_we,
   input  logic                               fill_commit,
   input  logic [ADDR_W-1:0]                  fill_line,
   input  logic [$clog2(WORDS)-1:0]           fill_word,
   input  logic [DATA_W-1:0]                  fill_data
);
   localparam int OFF_W  = $clog2(DATA_W / 8);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_LO = OFF_W + WSEL_W + IDX_W;
   localparam int TAG_W  = ADDR_W - TAG_LO;

   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] dat_q [LINES*WORDS];

   logic [IDX_W-1:0]  fidx;
   logic [TAG_W-1:0]  ftag;

   assign fidx = fill_line[OFF_W+WSEL_W +: IDX_W];
   assign ftag = fill_line[ADDR_W-1:TAG_LO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (fill_inval) begin
         vld_q[fidx] <= 1'b0;
      end else if (fill_commit) begin
         vld_q[fidx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_commit) begin
         tag_q[fidx] <= ftag;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         dat_q[{fidx, fill_word}] <= fill_data;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      logic [IDX_W-1:0]  ridx;
      logic [WSEL_W-1:0] rwrd;
      logic [TAG_W-1:0]  rtag;
      assign ridx       = rd_addr[p][OFF_W+WSEL_W +: IDX_W];
      assign rwrd       = rd_addr[p][OFF_W +: WSEL_W];
      assign rtag       = rd_addr[p][ADDR_W-1:TAG_LO];
      assign rd_hit[p]  = vld_q[ridx] && (tag_q[ridx] == rtag);
      assign rd_data[p] = dat_q[{ridx, rwrd}];
   end

   // R4: a committed line is valid in the following cycle
   a_r4_commit_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fill_commit |=> vld_q[$past(fidx)]);
endmodule

// File: rtl/icache_refill.sv
module icache_refill
   import dual_icache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  miss,
   input  logic [1:0][ADDR_W-1:0]      miss_addr,
   output logic                        mem_req_valid,
   output logic [ADDR_W-1:0]           mem_req_addr,
   input  logic                        mem_req_ready,
   input  logic                        mem_rsp_valid,
   input  logic [DATA_W-1:0]           mem_rsp_data,
   output logic                        busy,
   output logic                        fill_inval,
   output logic                        fill_we,
   output logic                        fill_commit,
   output logic [ADDR_W-1:0]           fill_line,
   output logic [$clog2(WORDS)-1:0]    fill_word,
   output logic [DATA_W-1:0]           fill_data
);
   localparam int WSEL_W  = $clog2(WORDS);
   localparam int LINE_LO = WSEL_W + $clog2(DATA_W / 8);
   localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

   refill_state_e     state_q, state_d;
   logic [ADDR_W-1:0] line_q, line_d;
   logic [WSEL_W-1:0] beat_q, beat_d;
   logic [ADDR_W-1:0] pick_addr;

   // port 0 carries the older fetch and wins a simultaneous miss
   assign pick_addr = miss[0] ? miss_addr[0] : miss_addr[1];

   always_comb begin
      state_d = state_q;
      line_d  = line_q;
      beat_d  = beat_q;
      unique case (state_q)
         RF_IDLE: if (|miss) begin
            line_d  = {pick_addr[ADDR_W-1:LINE_LO], LINE_LO'(0)};
            state_d = RF_REQ;
         end
         RF_REQ: if (mem_req_ready) begin
            beat_d  = '0;
            state_d = RF_WAIT;
         end
         RF_WAIT: if (mem_rsp_valid) begin
            beat_d = beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_d = RF_UPD;
         end
         RF_UPD: state_d = RF_IDLE;
         default: state_d = RF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RF_IDLE;
         line_q  <= '0;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         line_q  <= line_d;
         beat_q  <= beat_d;
      end
   end

   assign mem_req_valid = (state_q == RF_REQ);
   assign mem_req_addr  = line_q;
   assign busy          = (state_q == RF_WAIT) || (state_q == RF_UPD);
   assign fill_inval    = (state_q == RF_REQ) && mem_req_ready;
   assign fill_we       = (state_q == RF_WAIT) && mem_rsp_valid;
   assign fill_commit   = (state_q == RF_UPD);
   assign fill_line     = line_q;
   assign fill_word     = beat_q;
   assign fill_data     = mem_rsp_data;

   // R8: an unaccepted request holds valid and address
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R4: one handshake per refill
   a_r4_one_req_per_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: rtl/dual_icache.sv
module dual_icache #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 64,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f0_valid,
   input  logic [ADDR_W-1:0] f0_addr,
   output logic              f0_ready,
   output logic [DATA_W-1:0] f0_instr,
   input  logic              f1_valid,
   input  logic [ADDR_W-1:0] f1_addr,
   output logic              f1_ready,
   output logic [DATA_W-1:0] f1_instr,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam int WSEL_W  = $clog2(WORDS);
   localparam int IDX_LO  = WSEL_W + $clog2(DATA_W / 8);
   localparam int IDX_W   = $clog2(LINES);

   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (WORDS < 2 || (1 << WSEL_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (8 << $clog2(DATA_W / 8)) != DATA_W) begin : g_bad_data
      $error("DATA_W must be 8 times a power of two");
   end
   if (ADDR_W <= IDX_LO + IDX_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic [1:0][ADDR_W-1:0] lk_addr;
   logic [1:0]             lk_valid;
   logic [1:0]             lk_hit;
   logic [1:0][DATA_W-1:0] lk_data;
   logic [1:0]             lk_miss;

   logic                   busy;
   logic                   fill_inval, fill_we, fill_commit;
   logic [ADDR_W-1:0]      fill_line;
   logic [WSEL_W-1:0]      fill_word;
   logic [DATA_W-1:0]      fill_data;

   assign lk_addr  = {f1_addr, f0_addr};
   assign lk_valid = {f1_valid, f0_valid};
   assign lk_miss  = lk_valid & ~lk_hit;

   icache_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (lk_addr),
      .rd_hit      (lk_hit),
      .rd_data     (lk_data),
      .fill_inval  (fill_inval),
      .fill_we     (fill_we),
      .fill_commit (fill_commit),
      .fill_line   (fill_line),
      .fill_word   (fill_word),
      .fill_data   (fill_data)
   );

   icache_refill #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
   ) u_refill (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss          (lk_miss),
      .miss_addr     (lk_addr),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .busy          (busy),
      .fill_inval    (fill_inval),
      .fill_we       (fill_we),
      .fill_commit   (fill_commit),
      .fill_line     (fill_line),
      .fill_word     (fill_word),
      .fill_data     (fill_data)
   );

   assign f0_ready = lk_valid[0] & lk_hit[0];
   assign f1_ready = lk_valid[1] & lk_hit[1];
   assign f0_instr = lk_data[0];
   assign f1_instr = lk_data[1];

   // R11: the line under refill never produces a hit on either port
   a_r11_fill_line_no_hit0: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (f0_addr[IDX_LO +: IDX_W] == fill_line[IDX_LO +: IDX_W]) |-> !f0_ready);
   a_r11_fill_line_no_hit1: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (f1_addr[IDX_LO +: IDX_W] == fill_line[IDX_LO +: IDX_W]) |-> !f1_ready);
endmodule

// File: tb/dual_icache_tb_top.sv
module dual_icache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        f0_valid, f1_valid;
   logic [31:0] f0_addr, f1_addr;
   logic        f0_ready, f1_ready;
   logic [31:0] f0_instr, f1_instr;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int checks = 0;
   int fails  = 0;
   int req_cnt = 0;
   logic [31:0] req_log [0:1023];

   always #10 clk = ~clk;

   dual_icache dut_i (
      .clk(clk), .rst_n(rst_n),
      .f0_valid(f0_valid), .f0_addr(f0_addr), .f0_ready(f0_ready), .f0_instr(f0_instr),
      .f1_valid(f1_valid), .f1_addr(f1_addr), .f1_ready(f1_ready), .f1_instr(f1_instr),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] exp_word(input logic [31:0] a);
      return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] line_of(input logic [31:0] a);
      return {a[31:4], 4'h0};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // backing memory: random acceptance delay and beat gaps, driven at negedge
   initial begin : mem_model
      int          phase;
      int          beat;
      bit          pend;
      logic [31:0] pend_addr, base;
      phase = 0; beat = 0; pend = 0; pend_addr = '0; base = '0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_req_ready = 0;
         mem_rsp_valid = 0;
         if (!rst_n) begin
            phase = 0; pend = 0;
         end else if (phase == 0) begin
            if (mem_req_valid) begin
               if (pend) chk(mem_req_addr == pend_addr, "R8 request address drift",
                             mem_req_addr, pend_addr);
               pend = 1; pend_addr = mem_req_addr;
               if ($urandom_range(0, 2) == 0) begin
                  mem_req_ready = 1;
                  chk(mem_req_addr[3:0] == 4'h0, "R3 request line aligned",
                      mem_req_addr, line_of(mem_req_addr));
                  req_log[req_cnt % 1024] = mem_req_addr;
                  req_cnt++;
                  base = mem_req_addr; beat = 0; phase = 1; pend = 0;
               end
            end else begin
               pend = 0;
            end
         end else begin
            if ($urandom_range(0, 3) != 0) begin
               mem_rsp_valid = 1;
               mem_rsp_data  = exp_word(base + 32'(beat * 4));
               beat++;
               if (beat == 4) phase = 0;
            end
         end
      end
   end

   // drive a pair of lookups and hold each until its ready; latency -1 if unused
   task automatic access(input bit v0, input logic [31:0] a0,
                         input bit v1, input logic [31:0] a1,
                         output int lat0, output int lat1);
      bit d0, d1;
      @(negedge clk);
      f0_valid = v0; f0_addr = a0; f1_valid = v1; f1_addr = a1;
      d0 = !v0; d1 = !v1; lat0 = -1; lat1 = -1;
      for (int k = 0; k < 400 && !(d0 && d1); k++) begin
         #2;
         if (d0) chk(!f0_ready, "R10 port0 ready without valid", 32'(f0_ready), 0);
         if (d1) chk(!f1_ready, "R10 port1 ready without valid", 32'(f1_ready), 0);
         if (!d0 && f0_ready) begin
            chk(f0_instr == exp_word(a0), "R2 port0 word", f0_instr, exp_word(a0));
            lat0 = k; d0 = 1; f0_valid = 0;
         end
         if (!d1 && f1_ready) begin
            chk(f1_instr == exp_word(a1), "R2 port1 word", f1_instr, exp_word(a1));
            lat1 = k; d1 = 1; f1_valid = 0;
         end
         @(negedge clk);
      end
      chk(d0 && d1, "R3 lookup never completed", {30'd0, d1, d0}, 32'd3);
      f0_valid = 0; f1_valid = 0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int l0, l1, rc;
      logic [31:0] a, b, c, d, x, y;
      rst_n = 0; f0_valid = 0; f1_valid = 0; f0_addr = '0; f1_addr = '0;
      repeat (4) @(negedge clk);
      #2;
      chk(!mem_req_valid, "R1 no request in reset", 32'(mem_req_valid), 0);
      @(negedge clk); rst_n = 1;
      #2;
      chk(!f0_ready && !f1_ready, "R10 idle ports after reset",
          {30'd0, f1_ready, f0_ready}, 0);

      // R1, R3, R4: cold miss then the whole line hits
      a = 32'h0000_1234;
      rc = req_cnt;
      access(1, a, 0, 0, l0, l1);
      chk(l0 > 0, "R1 first lookup misses", 32'(l0), 1);
      chk(req_cnt == rc + 1, "R4 one request per line", 32'(req_cnt - rc), 1);
      chk(req_log[rc % 1024] == line_of(a), "R3 request is missing line",
          req_log[rc % 1024], line_of(a));
      for (int w = 0; w < 4; w++) begin
         access(1, line_of(a) + 32'(w * 4), 1, line_of(a) + 32'((3 - w) * 4), l0, l1);
         chk(l0 == 0 && l1 == 0, "R4 filled line hits on both ports",
             32'(l0 + l1), 0);
      end

      // R7: port0 misses while port1 hits
      b = 32'h0000_5678;
      access(1, b, 1, a, l0, l1);
      chk(l1 == 0, "R7 hit not blocked by other miss", 32'(l1), 0);
      chk(l0 > 0, "R7 other port misses", 32'(l0), 1);

      // R5: simultaneous misses on different lines
      c = 32'h0000_2A08; d = 32'h0000_3B04;
      rc = req_cnt;
      access(1, c, 1, d, l0, l1);
      chk(req_log[rc % 1024] == line_of(c), "R5 port0 line first",
          req_log[rc % 1024], line_of(c));
      chk(req_cnt == rc + 2, "R5 two refills", 32'(req_cnt - rc), 2);

      // R6 / R11: same line from both ports
      c = 32'h0000_4C00;
      rc = req_cnt;
      access(1, c, 1, c + 32'hC, l0, l1);
      chk(req_cnt == rc + 1, "R6 shared refill", 32'(req_cnt - rc), 1);
      chk(l1 > 0, "R11 no hit during refill of line", 32'(l1), 1);

      // R9: alias on one index evicts
      x = 32'h0000_0F50; y = x + 32'h0000_0400;
      access(1, x, 0, 0, l0, l1);
      access(1, y, 0, 0, l0, l1);
      rc = req_cnt;
      access(1, x, 0, 0, l0, l1);
      chk(l0 > 0 && req_cnt == rc + 1, "R9 evicted tag misses again",
          32'(req_cnt - rc), 1);

      // constrained random pairs over a small aliasing pool
      for (int n = 0; n < 400; n++) begin
         bit v0, v1;
         v0 = ($urandom_range(0, 3) != 0);
         v1 = ($urandom_range(0, 3) != 0);
         a = {20'd0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)),
              2'($urandom_range(0, 3)), 2'b00};
         b = {20'd0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)),
              2'($urandom_range(0, 3)), 2'b00};
         access(v0, a, v1, b, l0, l1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule